// File: doc/BRIEF.md
# Programmable Video Timing Generator

The block counts pixel clocks into lines and lines into fields, and drives active-high horizontal sync, vertical sync, active-video, field and pixel-request outputs for a display encoder. Software sets every segment width through a simple single-cycle write bus. In interlaced operation the odd field uses the main vertical pair and the even field uses a second vertical pair. All timing values are captured into shadow storage when a frame starts, so a write made in the middle of a frame takes effect only at the next frame.

Software starts video by setting the video-run bit. The block then emits a one-cycle frame-start strobe, which tells an upstream compositor to begin a frame. When software clears the bit, the current frame still runs to its end, and the bit keeps reading as one until the block is idle again. A status bit is set when the vertical front porch begins. It is cleared by writing one to it and can be routed to an interrupt line. A main control register provides a master enable, a request to flush the downstream FIFO, an automatic flush at each frame start, a stored wait-for-line-start flag and a one-bit output select.

Top module: `vtg_core`

## Requirements
- R1: A line is made of four segments in this order: sync (hsync high), back porch, active, front porch. Register 2 holds the sync width in bits [11:0] and the back porch in bits [27:16]. Register 3 holds the active width in bits [11:0] and the front porch in bits [27:16]. A width of zero counts as one pixel clock.
- R2: A field is made of four segments in this order, counted in lines: sync (vsync high for whole lines), back porch, active, front porch. Register 4 holds the sync lines in [11:0] and the back porch in [27:16]. Register 5 holds the active lines in [11:0] and the front porch in [27:16]. Zero counts as one line. The active output is high only where the horizontal and vertical active segments overlap.
- R3: Register 1 bit 2 selects interlace. With interlace set, each frame has an odd field (field output 0, vertical timing from registers 4 and 5) followed by an even field (field output 1, vertical timing from registers 6 and 7, same layout). The field output changes when the even field's first sync line begins.
- R4: When register 1 bit 0 (video run) is set and register 0 bit 0 (enable) is set, an idle block starts a frame on the next clock. frame_start is high for exactly that first cycle, together with hsync and vsync. At the end of a frame with run still set, the next frame starts immediately with another frame_start.
- R5: Register 1 bit 0 reads as one while a frame is running, even after software has written it to zero. Once the frame ends with run cleared, the block goes idle, all outputs are low, and the bit reads as zero.
- R6: Register 1 bit 1 selects continuous mode. When it is zero, the run bit is cleared as a frame starts, so exactly one frame is produced.
- R7: Register 9 bit 0 is set on the first cycle of the vertical front porch and cleared by writing one to it; a set in the same cycle wins over the clear. The irq output equals that status ANDed with register 8 bit 0.
- R8: Writing register 0 with bit 0 zero stops the block on the next clock. Writing register 0 with bit 1 set gives a one-cycle fifo_flush pulse; that bit always reads back as zero. With register 0 bit 2 set, fifo_flush also pulses together with each frame_start. out_sel follows register 0 bit 4.
- R9: Register 10 [11:0] holds a pixel count. pix_req is high in the active cycles whose offset from the start of the active segment is below that count. A count of zero requests no pixels.
- R10: Timing, pixel-count and interlace values written during a frame first take effect at the next frame start.
- R11: After reset all registers read as zero and all outputs are low. Reads are combinational from bus_addr. Registers 2 to 7 read back bits [11:0] and [27:16], register 0 reads back bits 0, 2, 3 and 4, and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| active | output | 1 | Active video region |
| field | output | 1 | 0 for the odd field, 1 for the even field |
| pix_req | output | 1 | Pixel request strobe |
| frame_start | output | 1 | One-cycle strobe at the start of a frame |
| fifo_flush | output | 1 | One-cycle downstream FIFO flush |
| out_sel | output | 1 | Output and clock select |
| irq | output | 1 | Vertical front porch interrupt |

## Verification
A wrong pixel or line counter moves an hsync or active edge within one line, and moves a vsync edge or the status bit within one field. The reference model compares every output and the read data on every cycle, so a fault shows up on the first cycle that differs. A wrong shadow capture or run-bit update appears only at a frame boundary. It shows up as a missing or extra frame_start, as read data that is wrong while the last frame drains, or as a per-frame active-cycle count that changes in the wrong frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int VTG_FW = 12;

    localparam int R_CTRL  = 0;
    localparam int R_VCTRL = 1;
    localparam int R_HA    = 2;
    localparam int R_HB    = 3;
    localparam int R_VA    = 4;
    localparam int R_VB    = 5;
    localparam int R_VAE   = 6;
    localparam int R_VBE   = 7;
    localparam int R_IEN   = 8;
    localparam int R_STAT  = 9;
    localparam int R_PIX   = 10;

    typedef logic [VTG_FW-1:0] fld_t;

    typedef struct packed {
        fld_t sync;
        fld_t back;
        fld_t act;
        fld_t front;
    } span_t;

    typedef struct packed {
        span_t h;
        span_t vo;
        span_t ve;
        fld_t  pix;
        logic  il;
    } tcfg_t;

    typedef enum logic [1:0] {PH_SYNC, PH_BACK, PH_ACT, PH_FRONT} phase_t;

    // last count of a segment; zero width behaves as one
    function automatic fld_t seg_last(phase_t p, span_t s);
        fld_t v;
        case (p)
            PH_SYNC: v = s.sync;
            PH_BACK: v = s.back;
            PH_ACT:  v = s.act;
            default: v = s.front;
        endcase
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic phase_t ph_next(phase_t p);
        return phase_t'(p + 2'd1);
    endfunction
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int HI_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              frame_go,
    input  logic              vfp_evt,
    input  logic              running,
    output tcfg_t             cfg,
    output logic              en,
    output logic              go,
    output logic              flush,
    output logic              sel,
    output logic              stat,
    output logic              irq
);
    localparam int HI_MSB = HI_LSB + VTG_FW - 1;

    typedef struct packed {
        logic  en, fas, wls, sel;
        logic  req, cont, il;
        span_t h, vo, ve;
        fld_t  pix;
        logic  ien, stat, flush;
    } rstate_t;

    rstate_t q, d;
    fld_t    lo, hi;
    int      idx;
    logic    unused_wbits;

    assign lo  = wdata[VTG_FW-1:0];
    assign hi  = wdata[HI_MSB:HI_LSB];
    assign idx = int'(addr);
    assign unused_wbits = ^wdata;

    always_comb begin
        d = q;
        d.flush = frame_go & q.fas;
        if (frame_go && !q.cont) d.req = 1'b0;
        if (wr) begin
            case (idx)
                R_CTRL:  begin
                    d.en = wdata[0]; d.flush = d.flush | wdata[1];
                    d.fas = wdata[2]; d.wls = wdata[3]; d.sel = wdata[4];
                end
                R_VCTRL: begin d.req = wdata[0]; d.cont = wdata[1]; d.il = wdata[2]; end
                R_HA:    begin d.h.sync = lo;  d.h.back = hi;  end
                R_HB:    begin d.h.act = lo;   d.h.front = hi; end
                R_VA:    begin d.vo.sync = lo; d.vo.back = hi; end
                R_VB:    begin d.vo.act = lo;  d.vo.front = hi; end
                R_VAE:   begin d.ve.sync = lo; d.ve.back = hi; end
                R_VBE:   begin d.ve.act = lo;  d.ve.front = hi; end
                R_IEN:   d.ien = wdata[0];
                R_STAT:  if (wdata[0]) d.stat = 1'b0;
                R_PIX:   d.pix = lo;
                default: ;
            endcase
        end
        if (vfp_evt) d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            R_CTRL:  rdata[4:0] = {q.sel, q.wls, q.fas, 1'b0, q.en};
            R_VCTRL: rdata[2:0] = {q.il, q.cont, q.req | running};
            R_HA:    begin rdata[VTG_FW-1:0] = q.h.sync;  rdata[HI_MSB:HI_LSB] = q.h.back;  end
            R_HB:    begin rdata[VTG_FW-1:0] = q.h.act;   rdata[HI_MSB:HI_LSB] = q.h.front; end
            R_VA:    begin rdata[VTG_FW-1:0] = q.vo.sync; rdata[HI_MSB:HI_LSB] = q.vo.back; end
            R_VB:    begin rdata[VTG_FW-1:0] = q.vo.act;  rdata[HI_MSB:HI_LSB] = q.vo.front; end
            R_VAE:   begin rdata[VTG_FW-1:0] = q.ve.sync; rdata[HI_MSB:HI_LSB] = q.ve.back; end
            R_VBE:   begin rdata[VTG_FW-1:0] = q.ve.act;  rdata[HI_MSB:HI_LSB] = q.ve.front; end
            R_IEN:   rdata[0] = q.ien;
            R_STAT:  rdata[0] = q.stat;
            R_PIX:   rdata[VTG_FW-1:0] = q.pix;
            default: ;
        endcase
    end

    assign cfg   = '{h: q.h, vo: q.vo, ve: q.ve, pix: q.pix, il: q.il};
    assign en    = q.en;
    assign go    = q.req & q.en;
    assign flush = q.flush;
    assign sel   = q.sel;
    assign stat  = q.stat;
    assign irq   = q.stat & q.ien;
endmodule

// File: rtl/vtg_engine.sv
module vtg_engine
    import vtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  go,
    input  tcfg_t cfg,
    output logic  frame_go,
    output logic  vfp_evt,
    output logic  running,
    output logic  hsync,
    output logic  vsync,
    output logic  active,
    output logic  field,
    output logic  pix_req,
    output logic  frame_start
);
    typedef struct packed {
        logic   running, field, fs;
        phase_t hph, vph;
        fld_t   hcnt, vcnt;
        tcfg_t  sh;
    } estate_t;

    estate_t q, d;
    span_t   vt;
    logic    h_last, v_last, line_end, field_end, even_next;

    always_comb begin
        vt        = q.field ? q.sh.ve : q.sh.vo;
        h_last    = (q.hcnt == seg_last(q.hph, q.sh.h));
        v_last    = (q.vcnt == seg_last(q.vph, vt));
        line_end  = q.running && h_last && (q.hph == PH_FRONT);
        field_end = line_end && v_last && (q.vph == PH_FRONT);
        vfp_evt   = line_end && v_last && (q.vph == PH_ACT);
        even_next = field_end && q.sh.il && !q.field;
        frame_go  = go && (!q.running || (field_end && !even_next));

        d = q;
        d.fs = 1'b0;
        if (!en) begin
            d.running = 1'b0;
        end else if (q.running) begin
            if (h_last) begin
                d.hcnt = '0;
                d.hph  = ph_next(q.hph);
            end else begin
                d.hcnt = q.hcnt + 1'b1;
            end
            if (line_end) begin
                if (v_last) begin
                    d.vcnt = '0;
                    d.vph  = ph_next(q.vph);
                end else begin
                    d.vcnt = q.vcnt + 1'b1;
                end
            end
            if (field_end) begin
                if (even_next) d.field   = 1'b1;
                else if (!go)  d.running = 1'b0;
            end
        end
        if (frame_go) begin
            d.running = 1'b1;
            d.field   = 1'b0;
            d.hph     = PH_SYNC;
            d.vph     = PH_SYNC;
            d.hcnt    = '0;
            d.vcnt    = '0;
            d.sh      = cfg;
            d.fs      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign running     = q.running;
    assign hsync       = q.running && (q.hph == PH_SYNC);
    assign vsync       = q.running && (q.vph == PH_SYNC);
    assign active      = q.running && (q.hph == PH_ACT) && (q.vph == PH_ACT);
    assign field       = q.running && q.field;
    assign pix_req     = active && (q.hcnt < q.sh.pix);
    assign frame_start = q.fs;
endmodule

// File: rtl/vtg_core.sv
module vtg_core
    import vtg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int HI_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              hsync,
    output logic              vsync,
    output logic              active,
    output logic              field,
    output logic              pix_req,
    output logic              frame_start,
    output logic              fifo_flush,
    output logic              out_sel,
    output logic              irq
);
    tcfg_t cfg;
    logic  ctrl_en, go, frame_go, vfp_evt, running, stat;

    vtg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_LSB(HI_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .frame_go(frame_go),
        .vfp_evt(vfp_evt), .running(running), .cfg(cfg), .en(ctrl_en),
        .go(go), .flush(fifo_flush), .sel(out_sel), .stat(stat), .irq(irq)
    );

    vtg_engine u_eng (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .go(go), .cfg(cfg),
        .frame_go(frame_go), .vfp_evt(vfp_evt), .running(running),
        .hsync(hsync), .vsync(vsync), .active(active), .field(field),
        .pix_req(pix_req), .frame_start(frame_start)
    );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic vsync,
    input logic active,
    input logic pix_req,
    input logic field,
    input logic frame_start,
    input logic ctrl_en,
    input logic running,
    input logic vfp_evt,
    input logic stat
);
    p_hs_not_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !hsync);
    p_vs_not_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |-> !active);
    p_field_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(field) |-> (hsync && vsync && !frame_start));
    p_fs_at_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (hsync && vsync && !field));
    p_fs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    p_stat_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vfp_evt |=> stat);
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !running);
    p_pix_in_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> active);
endmodule

bind vtg_core vtg_checker u_chk (.*);

// File: tb/vtg_core_test.sv
module vtg_core_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic hsync, vsync, active, field, pix_req, frame_start, fifo_flush, out_sel, irq;

    vtg_core uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync),
        .vsync(vsync), .active(active), .field(field), .pix_req(pix_req),
        .frame_start(frame_start), .fifo_flush(fifo_flush),
        .out_sel(out_sel), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    int m_reg [16];
    int m_stat = 0, m_run = 0, m_field = 0, m_h = 0, m_v = 0, m_fs = 0, m_flush = 0;
    int s_hs = 0, s_hb = 0, s_ha = 0, s_hf = 0, s_pc = 0, s_il = 0;
    int s_vs [2], s_vb [2], s_va [2], s_vf [2];
    int fs_cnt = 0, act_cur = 0, act_last = 0, flush_cnt = 0;
    bit field_seen = 0, irq_seen = 0;

    function automatic int L(int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            0: return m_reg[0] & 'h1D;
            1: return (m_reg[1] & 7) | m_run;
            2, 3, 4, 5, 6, 7: return m_reg[a] & 'h0FFF0FFF;
            8: return m_reg[8] & 1;
            9: return m_stat;
            10: return m_reg[10] & 'hFFF;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        for (int i = 0; i < 2; i++) begin s_vs[i] = 0; s_vb[i] = 0; s_va[i] = 0; s_vf[i] = 0; end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_reg[i] = 0;
            m_stat = 0; m_run = 0; m_field = 0; m_h = 0; m_v = 0; m_fs = 0; m_flush = 0;
        end else begin
            int ht, vt, vfp_line;
            bit en, go, st, fe, vfp;
            en = m_reg[0][0];
            go = m_reg[1][0] && en;
            st = 0; fe = 0; vfp = 0;
            ht = L(s_hs) + L(s_hb) + L(s_ha) + L(s_hf);
            vt = L(s_vs[m_field]) + L(s_vb[m_field]) + L(s_va[m_field]) + L(s_vf[m_field]);
            vfp_line = L(s_vs[m_field]) + L(s_vb[m_field]) + L(s_va[m_field]);
            if (!en) m_run = 0;
            else if (m_run != 0) begin
                if (m_h == ht - 1) begin
                    m_h = 0;
                    if (m_v == vt - 1) fe = 1;
                    else begin
                        m_v++;
                        if (m_v == vfp_line) vfp = 1;
                    end
                end else m_h++;
                if (fe) begin
                    if (s_il != 0 && m_field == 0) begin m_field = 1; m_v = 0; end
                    else if (go) st = 1;
                    else m_run = 0;
                end
            end else if (go) st = 1;
            if (st) begin
                s_hs = m_reg[2] & 'hFFF; s_hb = (m_reg[2] >> 16) & 'hFFF;
                s_ha = m_reg[3] & 'hFFF; s_hf = (m_reg[3] >> 16) & 'hFFF;
                for (int f = 0; f < 2; f++) begin
                    s_vs[f] = m_reg[4+2*f] & 'hFFF; s_vb[f] = (m_reg[4+2*f] >> 16) & 'hFFF;
                    s_va[f] = m_reg[5+2*f] & 'hFFF; s_vf[f] = (m_reg[5+2*f] >> 16) & 'hFFF;
                end
                s_pc = m_reg[10] & 'hFFF;
                s_il = m_reg[1][2];
                m_run = 1; m_h = 0; m_v = 0; m_field = 0;
            end
            m_fs = st;
            m_flush = (st && m_reg[0][2]) || (bus_wr && bus_addr == 0 && bus_wdata[1]);
            if (st && !m_reg[1][1]) m_reg[1][0] = 1'b0;
            if (bus_wr && bus_addr == 9 && bus_wdata[0]) m_stat = 0;
            if (vfp) m_stat = 1;
            if (bus_wr && bus_addr != 9) m_reg[bus_addr] = bus_wdata;
        end
    end

    // compare every cycle, a quarter period after the edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (rst_n && !done) begin
            int hst, vst, e_act, ra;
            string rtag;
            hst = L(s_hs) + L(s_hb);
            vst = L(s_vs[m_field]) + L(s_vb[m_field]);
            e_act = (m_run != 0) && m_h >= hst && m_h < hst + L(s_ha) &&
                    m_v >= vst && m_v < vst + L(s_va[m_field]);
            chk(hsync, (m_run != 0) && m_h < L(s_hs), "R1 hsync");
            chk(active, e_act, "R1 active");
            chk(vsync, (m_run != 0) && m_v < L(s_vs[m_field]), "R2 vsync");
            chk(field, (m_run != 0) && m_field != 0, "R3 field");
            chk(frame_start, m_fs, "R4 frame_start");
            chk(pix_req, e_act && (m_h - hst) < s_pc, "R9 pix_req");
            chk(irq, m_stat & (m_reg[8] & 1), "R7 irq");
            chk(fifo_flush, m_flush, "R8 fifo_flush");
            chk(out_sel, m_reg[0][4], "R8 out_sel");
            ra = bus_addr;
            rtag = (ra == 1) ? "R5 rdata" : (ra == 9) ? "R7 rdata" : "R11 rdata";
            chk(bus_rdata, exp_rd(ra), rtag);
            if (frame_start) begin fs_cnt++; act_last = act_cur; act_cur = 0; end
            if (active) act_cur++;
            if (field) field_seen = 1;
            if (irq) irq_seen = 1;
            if (fifo_flush) flush_cnt++;
        end
    end

    task automatic wr(input int a, input int dat);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = dat;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'd1;
    endtask

    task automatic run_frames(input int n);
        int target;
        target = fs_cnt + n;
        while (fs_cnt < target) begin
            @(negedge clk);
            if (irq) wr(9, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        int fs0, fl0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values
        for (int a = 0; a < 11; a++) begin
            bus_addr = 4'(a);
            @(negedge clk);
            chk(bus_rdata, 0, "R11 reset read");
        end
        chk(hsync | vsync | active | irq, 0, "R11 reset outputs");

        // progressive continuous run, R1 R2 R4 R7
        wr(2, 2 | (3 << 16)); wr(3, 4 | (2 << 16));
        wr(4, 1 | (2 << 16)); wr(5, 3 | (2 << 16));
        wr(6, 1 | (1 << 16)); wr(7, 3 | (2 << 16));
        wr(10, 4); wr(8, 1); wr(0, 1 | 16); wr(1, 3);
        fs0 = fs_cnt;
        run_frames(3);
        chk(fs_cnt - fs0, 3, "R4 frame count");
        chk(irq_seen, 1, "R7 irq raised");

        // R10 mid-frame change applies next frame
        repeat (20) @(negedge clk);
        wr(3, 5 | (2 << 16)); wr(10, 8);
        run_frames(1);
        chk(act_last, 12, "R10 old frame active cycles");
        run_frames(1);
        chk(act_last, 15, "R10 new frame active cycles");

        // zero widths count as one, R1 R2
        wr(2, 0); wr(3, 3); wr(4, 0); wr(5, 2); wr(10, 2);
        run_frames(2);
        chk(act_last, 6, "R2 zero width frame active cycles");

        // interlace R3
        wr(2, 2 | (3 << 16)); wr(3, 4 | (2 << 16));
        wr(4, 1 | (2 << 16)); wr(5, 3 | (2 << 16)); wr(10, 4);
        wr(1, 7);
        run_frames(3);
        chk(field_seen, 1, "R3 even field seen");
        chk(act_last, 24, "R3 interlaced frame active cycles");

        // R5 stop drains the current frame
        repeat (5) @(negedge clk);
        fs0 = fs_cnt;
        wr(1, 0);
        bus_addr = 4'd1;
        @(negedge clk);
        chk(bus_rdata[0], 1, "R5 run reads one while draining");
        for (int i = 0; i < 400 && bus_rdata[0]; i++) @(negedge clk);
        @(negedge clk);
        chk(bus_rdata[0], 0, "R5 run reads zero after drain");
        chk({hsync, vsync, active, field}, 0, "R5 idle outputs");
        chk(fs_cnt - fs0, 0, "R5 no new frame");

        // R6 single frame
        fs0 = fs_cnt;
        wr(1, 1);
        repeat (400) @(negedge clk);
        chk(fs_cnt - fs0, 1, "R6 one frame only");
        bus_addr = 4'd1;
        @(negedge clk);
        chk(bus_rdata[0], 0, "R6 run cleared");

        // R8 abort and flush
        wr(1, 3);
        run_frames(1);
        repeat (10) @(negedge clk);
        wr(0, 0);
        @(negedge clk);
        chk({hsync, vsync, active}, 0, "R8 abort idles");
        fl0 = flush_cnt;
        wr(0, 3);
        chk(flush_cnt - fl0, 1, "R8 flush on write");
        wr(0, 1 | 4);
        fl0 = flush_cnt;
        run_frames(1);
        @(negedge clk);
        chk(flush_cnt - fl0, 1, "R8 flush at frame start");
        bus_addr = 4'd0;
        @(negedge clk);
        chk(bus_rdata, 5, "R8 flush bit reads zero");

        done = 1;
        summary();
        $finish;
    end
endmodule